// File: doc/BRIEF.md
# Vector Indexed Atomic Sequencer

This block carries out one vector indexed atomic memory instruction, one element after another. A start pulse delivers the 32-bit instruction word, a scalar base address, the vector length, the first element to process, the data element width code and a per-element mask. The block decodes the instruction and checks that it is legal. It then walks the elements in order. For each active element it reads the index element and the operand element through a register read port. It then performs a locked read-modify-write on memory at the base address plus the index. When the instruction asks for it, the old memory value goes back into the destination register.

The memory request channel is valid/ready. A request stays on the port, unchanged, until `mem_req_ready` is seen high at a clock edge. The response channel is also valid/ready: `mem_rsp_ready` is high only while the block waits for a response, and the memory holds `mem_rsp_valid` and its data until that handshake completes. The register read port has a fixed latency of one cycle. The register write port is fire-and-forget. Control and status pins are plain levels or single-cycle pulses.

Top module: `vec_amo_seq`

## Requirements
- R1: An instruction is legal only if bits 6:0 equal 0x2F and bits 31:27 hold one of nine function codes: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. Any other opcode or function code is illegal.
- R2: Bits 14:12 select the index element width: 000 = 8 bits, 101 = 16 bits, 110 = 32 bits, 111 = 64 bits. Any other code is illegal. Index bits above the selected width are ignored, which means the index is zero-extended.
- R3: `sew_code` selects the data width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Only 32 bits, and 64 bits when XLEN is at least 64, are legal. An illegal instruction gives a one-cycle `illegal` pulse instead of `done`, makes no memory request and leaves `vstart_q` unchanged.
- R4: The memory address of element i is `base_addr` plus the zero-extended index element i.
- R5: The value stored to memory is f(old, operand), where the operand is element i of the destination register. Swap stores the operand. Add wraps modulo the data width. Xor, and and or are bitwise. A 32-bit access uses and writes only the low 32 bits.
- R6: Min keeps the old value when old < operand and max keeps it when old >= operand; otherwise the operand is stored. The signed forms compare as two's complement at the data width, and the unsigned forms compare as unsigned.
- R7: When bit 26 is set, the old memory value (zero-extended to XLEN) is written to destination element i. When bit 26 is clear, the destination register is never written.
- R8: Elements are processed in ascending order from `vstart_in` to `vl`-1. `vstart_q` takes `vstart_in` when a legal instruction starts and reads zero from the cycle after `done`.
- R9: When bit 25 is 0, masking is on: an element whose `mask_in` bit is 0 makes no memory request and no write-back. When bit 25 is 1, every element is active.
- R10: `mem_lock` is high from the read request of an element until the response to its write request. Each element issues exactly one read followed by one write. The next element's requests wait until the lock has dropped.
- R11: `done` pulses for one cycle after the last element. If `vstart_in` is not below `vl`, `done` pulses in the cycle after start, with no memory request.
- R12: After reset there is no request, no lock and no pulse. A request that is not accepted keeps its address, direction and data stable.
- R13: A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| insn | input | 32 | Instruction word |
| base_addr | input | XLEN | Scalar base address |
| vl | input | IDXW | Vector length (at most NELEM) |
| vstart_in | input | IDXW | First element to process |
| sew_code | input | 2 | Data element width code |
| mask_in | input | NELEM | Per-element mask bits |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| vstart_q | output | IDXW | Start-index register |
| rf_rd_en | output | 1 | Register read request |
| rf_rd_sel | output | 1 | 0 = index register, 1 = destination register |
| rf_rd_elem | output | EW | Element number to read |
| rf_rd_data | input | XLEN | Read data, right-aligned, one cycle after rf_rd_en |
| wb_valid | output | 1 | Destination write strobe |
| wb_elem | output | EW | Destination element number |
| wb_data | output | XLEN | Old memory value written back |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_size64 | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_req_addr | output | XLEN | Request address |
| mem_req_wdata | output | XLEN | Write data, right-aligned |
| mem_lock | output | 1 | Keeps the read-modify-write indivisible |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_ready | output | 1 | Block accepts a response |
| mem_rsp_rdata | input | XLEN | Read response data |

## Verification
A wrong element counter or mask lookup shows up as a memory word or destination element that differs from the computed reference. It can also show up as a request count that is off by two per element, and either one is visible at the `done` of the same instruction. A wrong operation select, sign handling or SEW mask corrupts the first memory word that element touches. The sweep drives edge values and equal operands, so min/max ties and sign-bit cases expose it within one instruction. A broken lock or handshake shows up in the cycle it happens: a request without the lock, a request that changes while stalled, or a lock that drops without a response.

// File: rtl/vec_amo_pkg.sv
package vec_amo_pkg;

  typedef enum logic [3:0] {
    FN_SWAP, FN_ADD, FN_XOR, FN_AND, FN_OR,
    FN_MIN, FN_MAX, FN_MINU, FN_MAXU
  } amo_fn_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PICK, ST_IDX, ST_OPD, ST_RREQ,
    ST_RRSP, ST_WREQ, ST_WRSP, ST_NEXT, ST_DONE, ST_ERR
  } seq_st_e;

  typedef struct packed {
    amo_fn_e    fn;
    logic       keep_old;   // write old value back
    logic       masked;     // mask bits apply
    logic [1:0] iw_code;    // 0:8 1:16 2:32 3:64 index bits
    logic       sew64;      // 64-bit data elements
  } amo_cmd_t;

  localparam logic [6:0] AMO_MAJOR = 7'h2F;

endpackage

// File: rtl/vec_amo_decode.sv
module vec_amo_decode
  import vec_amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] insn,
  input  logic [1:0]  sew_code,
  output amo_cmd_t    cmd,
  output logic        legal
);

  logic fn_ok, w_ok, sew_ok, op_ok;
  logic unused_fields;

  assign unused_fields = ^{insn[24:15], insn[11:7]};

  always_comb begin
    fn_ok  = 1'b1;
    cmd.fn = FN_ADD;
    unique case (insn[31:27])
      5'b00001: cmd.fn = FN_SWAP;
      5'b00000: cmd.fn = FN_ADD;
      5'b00100: cmd.fn = FN_XOR;
      5'b01100: cmd.fn = FN_AND;
      5'b01000: cmd.fn = FN_OR;
      5'b10000: cmd.fn = FN_MIN;
      5'b10100: cmd.fn = FN_MAX;
      5'b11000: cmd.fn = FN_MINU;
      5'b11100: cmd.fn = FN_MAXU;
      default:  fn_ok  = 1'b0;
    endcase
  end

  always_comb begin
    w_ok        = 1'b1;
    cmd.iw_code = 2'd0;
    unique case (insn[14:12])
      3'b000:  cmd.iw_code = 2'd0;
      3'b101:  cmd.iw_code = 2'd1;
      3'b110:  cmd.iw_code = 2'd2;
      3'b111:  cmd.iw_code = 2'd3;
      default: w_ok = 1'b0;
    endcase
  end

  assign cmd.keep_old = insn[26];
  assign cmd.masked   = ~insn[25];
  assign cmd.sew64    = (sew_code == 2'd3);
  assign sew_ok       = (sew_code == 2'd2) || ((sew_code == 2'd3) && (XLEN >= 64));
  assign op_ok        = (insn[6:0] == AMO_MAJOR);
  assign legal        = op_ok && fn_ok && w_ok && sew_ok;

endmodule

// File: rtl/vec_amo_addr.sv
module vec_amo_addr #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] raw_idx,
  input  logic [1:0]      iw_code,
  output logic [XLEN-1:0] addr
);

  logic [XLEN-1:0] keep;
  int              nbits;

  always_comb begin
    nbits = 8 << iw_code;
    for (int b = 0; b < XLEN; b++) keep[b] = (b < nbits);
  end

  assign addr = base + (raw_idx & keep);

endmodule

// File: rtl/vec_amo_alu.sv
module vec_amo_alu
  import vec_amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_fn_e         fn,
  input  logic            sew64,
  input  logic [XLEN-1:0] old_v,   // zero-extended at SEW
  input  logic [XLEN-1:0] opd_v,   // zero-extended at SEW
  output logic [XLEN-1:0] res
);

  logic [XLEN-1:0] old_sx, opd_sx, lanes, raw;
  logic            lt_s, lt_u;

  always_comb begin
    for (int b = 0; b < XLEN; b++) begin
      lanes[b]  = (b < 32) || sew64;
      old_sx[b] = ((b < 32) || sew64) ? old_v[b] : old_v[31];
      opd_sx[b] = ((b < 32) || sew64) ? opd_v[b] : opd_v[31];
    end
  end

  assign lt_s = $signed(old_sx) < $signed(opd_sx);
  assign lt_u = old_v < opd_v;

  always_comb begin
    unique case (fn)
      FN_SWAP: raw = opd_v;
      FN_ADD:  raw = old_v + opd_v;
      FN_XOR:  raw = old_v ^ opd_v;
      FN_AND:  raw = old_v & opd_v;
      FN_OR:   raw = old_v | opd_v;
      FN_MIN:  raw = lt_s ? old_v : opd_v;
      FN_MAX:  raw = lt_s ? opd_v : old_v;
      FN_MINU: raw = lt_u ? old_v : opd_v;
      FN_MAXU: raw = lt_u ? opd_v : old_v;
      default: raw = opd_v;
    endcase
  end

  assign res = raw & lanes;

endmodule

// File: rtl/vec_amo_seq.sv
module vec_amo_seq
  import vec_amo_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NELEM = 16,
  localparam int IDXW = $clog2(NELEM + 1),
  localparam int EW   = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  base_addr,
  input  logic [IDXW-1:0]  vl,
  input  logic [IDXW-1:0]  vstart_in,
  input  logic [1:0]       sew_code,
  input  logic [NELEM-1:0] mask_in,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [IDXW-1:0]  vstart_q,
  output logic             rf_rd_en,
  output logic             rf_rd_sel,
  output logic [EW-1:0]    rf_rd_elem,
  input  logic [XLEN-1:0]  rf_rd_data,
  output logic             wb_valid,
  output logic [EW-1:0]    wb_elem,
  output logic [XLEN-1:0]  wb_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic             mem_req_size64,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [XLEN-1:0]  mem_req_wdata,
  output logic             mem_lock,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [XLEN-1:0]  mem_rsp_rdata
);

  seq_st_e          st_q;
  amo_cmd_t         cmd_q, cmd_d;
  logic             legal_d;
  logic [XLEN-1:0]  base_q, addr_q, opd_q, old_q;
  logic [IDXW-1:0]  vl_q, elem_q;
  logic [NELEM-1:0] mask_q;
  logic [EW-1:0]    elem_lo;
  logic [XLEN-1:0]  sew_keep, addr_calc, new_val;
  logic             elem_on, last_elem;

  vec_amo_decode #(.XLEN(XLEN)) u_dec (
    .insn     (insn),
    .sew_code (sew_code),
    .cmd      (cmd_d),
    .legal    (legal_d)
  );

  vec_amo_addr #(.XLEN(XLEN)) u_addr (
    .base    (base_q),
    .raw_idx (rf_rd_data),
    .iw_code (cmd_q.iw_code),
    .addr    (addr_calc)
  );

  vec_amo_alu #(.XLEN(XLEN)) u_alu (
    .fn    (cmd_q.fn),
    .sew64 (cmd_q.sew64),
    .old_v (old_q),
    .opd_v (opd_q),
    .res   (new_val)
  );

  always_comb begin
    for (int b = 0; b < XLEN; b++) sew_keep[b] = (b < 32) || cmd_q.sew64;
  end

  assign elem_lo   = elem_q[EW-1:0];
  assign elem_on   = !cmd_q.masked || mask_q[elem_lo];
  assign last_elem = ({1'b0, elem_q} + 1'b1) >= {1'b0, vl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cmd_q    <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      opd_q    <= '0;
      old_q    <= '0;
      vl_q     <= '0;
      elem_q   <= '0;
      mask_q   <= '0;
      vstart_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (!legal_d) begin
            st_q <= ST_ERR;
          end else begin
            cmd_q    <= cmd_d;
            base_q   <= base_addr;
            vl_q     <= vl;
            mask_q   <= mask_in;
            elem_q   <= vstart_in;
            vstart_q <= vstart_in;
            st_q     <= (vstart_in >= vl) ? ST_DONE : ST_PICK;
          end
        end
        ST_PICK: begin
          if (elem_on) st_q <= ST_IDX;
          else if (last_elem) st_q <= ST_DONE;
          else elem_q <= elem_q + 1'b1;
        end
        ST_IDX: begin
          addr_q <= addr_calc;
          st_q   <= ST_OPD;
        end
        ST_OPD: begin
          opd_q <= rf_rd_data & sew_keep;
          st_q  <= ST_RREQ;
        end
        ST_RREQ: if (mem_req_ready) st_q <= ST_RRSP;
        ST_RRSP: if (mem_rsp_valid) begin
          old_q <= mem_rsp_rdata & sew_keep;
          st_q  <= ST_WREQ;
        end
        ST_WREQ: if (mem_req_ready) st_q <= ST_WRSP;
        ST_WRSP: if (mem_rsp_valid) st_q <= ST_NEXT;
        ST_NEXT: begin
          if (last_elem) st_q <= ST_DONE;
          else begin
            elem_q <= elem_q + 1'b1;
            st_q   <= ST_PICK;
          end
        end
        ST_DONE: begin
          vstart_q <= '0;
          st_q     <= ST_IDLE;
        end
        ST_ERR:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_DONE);
  assign illegal = (st_q == ST_ERR);

  assign rf_rd_en   = ((st_q == ST_PICK) && elem_on) || (st_q == ST_IDX);
  assign rf_rd_sel  = (st_q == ST_IDX);
  assign rf_rd_elem = elem_lo;

  assign wb_valid = (st_q == ST_NEXT) && cmd_q.keep_old;
  assign wb_elem  = elem_lo;
  assign wb_data  = old_q;

  assign mem_req_valid  = (st_q == ST_RREQ) || (st_q == ST_WREQ);
  assign mem_req_write  = (st_q == ST_WREQ);
  assign mem_req_size64 = cmd_q.sew64;
  assign mem_req_addr   = addr_q;
  assign mem_req_wdata  = (st_q == ST_WREQ) ? new_val : '0;
  assign mem_lock       = (st_q == ST_RREQ) || (st_q == ST_RRSP) ||
                          (st_q == ST_WREQ) || (st_q == ST_WRSP);
  assign mem_rsp_ready  = (st_q == ST_RRSP) || (st_q == ST_WRSP);

endmodule

// File: rtl/vec_amo_seq_chk.sv
module vec_amo_seq_chk #(
  parameter int XLEN  = 64,
  parameter int NELEM = 16,
  localparam int IDXW = $clog2(NELEM + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic [IDXW-1:0] vstart_q,
  input logic            wb_valid,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [XLEN-1:0] mem_req_addr,
  input logic [XLEN-1:0] mem_req_wdata,
  input logic            mem_lock,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready
);

  a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r10_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_lock);

  a_r10_unlock_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> $past(mem_rsp_valid && mem_rsp_ready));

  a_r7_wb_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !mem_lock);

  a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));

  a_r8_vstart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> vstart_q == '0);

  a_r3_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_lock && !mem_req_valid);

  a_r13_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || illegal) |=> !busy);

endmodule

bind vec_amo_seq vec_amo_seq_chk #(.XLEN(XLEN), .NELEM(NELEM)) u_chk (.*);

// File: tb/vec_amo_seq_bench.sv
`timescale 1ns/1ps
module vec_amo_seq_bench;
  localparam int XLEN  = 64;
  localparam int NELEM = 8;
  localparam int IDXW  = $clog2(NELEM + 1);
  localparam int EW    = $clog2(NELEM);
  localparam logic [63:0] BASE = 64'h1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      insn = '0;
  logic [XLEN-1:0]  base_addr = BASE;
  logic [IDXW-1:0]  vl = '0, vstart_in = '0;
  logic [1:0]       sew_code = 2'd2;
  logic [NELEM-1:0] mask_in = '0;
  logic             busy, done, illegal;
  logic [IDXW-1:0]  vstart_q;
  logic             rf_rd_en, rf_rd_sel;
  logic [EW-1:0]    rf_rd_elem;
  logic [XLEN-1:0]  rf_rd_data = '0;
  logic             wb_valid;
  logic [EW-1:0]    wb_elem;
  logic [XLEN-1:0]  wb_data;
  logic             mem_req_valid, mem_req_ready = 1'b0, mem_req_write, mem_req_size64;
  logic [XLEN-1:0]  mem_req_addr, mem_req_wdata;
  logic             mem_lock, mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [XLEN-1:0]  mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  vec_amo_seq #(.XLEN(XLEN), .NELEM(NELEM)) u_vec_amo_seq (.*);

  logic [63:0] idx_rf [NELEM];
  logic [63:0] opd_rf [NELEM];
  logic [63:0] mem    [64];
  logic [63:0] exp_mem [64];
  logic [63:0] exp_opd [NELEM];
  int n_req = 0, n_chk = 0, n_fail = 0, cyc = 0, bad_addr = 0;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  // register file model
  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= rf_rd_sel ? opd_rf[rf_rd_elem] : idx_rf[rf_rd_elem];
    if (wb_valid) opd_rf[wb_elem] <= wb_data;
  end

  // memory model with back-pressure
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
  end

  always @(posedge clk) begin
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr < BASE || mem_req_addr >= BASE + 512 || mem_req_addr[2:0] != 0)
        bad_addr <= bad_addr + 1;
      else if (mem_req_write) begin
        if (mem_req_size64) mem[(mem_req_addr - BASE) >> 3] <= mem_req_wdata;
        else mem[(mem_req_addr - BASE) >> 3][31:0] <= mem_req_wdata[31:0];
      end else mem_rsp_rdata <= mem[(mem_req_addr - BASE) >> 3];
      mem_rsp_valid <= 1'b1;
      n_req <= n_req + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rnd(output logic [63:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    v = rs;
  endtask

  task automatic pick_val(output logic [63:0] v);
    logic [63:0] r, e;
    rnd(r);
    rnd(e);
    if (r[1:0] == 2'd0) begin
      case (e % 6)
        0: v = 64'h0;
        1: v = 64'h1;
        2: v = '1;
        3: v = 64'h8000_0000;
        4: v = 64'h7FFF_FFFF;
        default: v = 64'h8000_0000_0000_0000;
      endcase
    end else v = e;
  endtask

  function automatic logic [63:0] ref_op(int f5, bit s64, logic [63:0] o, logic [63:0] p);
    logic [63:0] r;
    longint so, sp;
    so = s64 ? longint'(o) : longint'($signed(o[31:0]));
    sp = s64 ? longint'(p) : longint'($signed(p[31:0]));
    case (f5)
      1:  r = p;
      0:  r = o + p;
      4:  r = o ^ p;
      12: r = o & p;
      8:  r = o | p;
      16: r = (so < sp) ? o : p;
      20: r = (so >= sp) ? o : p;
      24: r = (o < p) ? o : p;
      default: r = (o >= p) ? o : p;
    endcase
    if (!s64) r[63:32] = '0;
    return r;
  endfunction

  task automatic run(input int f5, input bit wd, input bit msk, input int wc, input int sewc,
                     input int op7, input int vs, input int vlen, input bit poke,
                     input bit exp_ill, input string tag);
    int iwb, req0, exp_req, a;
    logic [63:0] r, k, o, p, ix, vprev;
    bit got_done, got_ill, mem_ok, opd_ok;
    logic [NELEM-1:0] mv;
    iwb = (wc == 0) ? 8 : (wc == 5) ? 16 : (wc == 6) ? 32 : 64;
    rnd(r);
    mv = r[NELEM-1:0];
    for (int w = 0; w < 64; w++) begin pick_val(r); mem[w] = r; end
    for (int i = 0; i < NELEM; i++) begin
      rnd(r); rnd(k);
      ix = (k % 32) * 8;
      if (iwb < 64) ix = ix | (r << iwb);
      idx_rf[i] = ix;
      pick_val(r);
      opd_rf[i] = r;
      if (k[9:7] == 3'd0) opd_rf[i] = mem[(k % 32)];
    end
    // reference model
    for (int w = 0; w < 64; w++) exp_mem[w] = mem[w];
    for (int i = 0; i < NELEM; i++) exp_opd[i] = opd_rf[i];
    exp_req = 0;
    if (!exp_ill) begin
      for (int i = vs; i < vlen; i++) begin
        if (msk && !mv[i]) continue;
        ix = idx_rf[i];
        if (iwb < 64) ix = ix & ((64'h1 << iwb) - 1);
        a = int'(ix >> 3);
        o = (sewc == 3) ? exp_mem[a] : {32'h0, exp_mem[a][31:0]};
        p = (sewc == 3) ? exp_opd[i] : {32'h0, exp_opd[i][31:0]};
        r = ref_op(f5, sewc == 3, o, p);
        if (sewc == 3) exp_mem[a] = r; else exp_mem[a][31:0] = r[31:0];
        if (wd) exp_opd[i] = o;
        exp_req += 2;
      end
    end
    vprev = 64'(vstart_q);
    req0 = n_req;
    @(negedge clk);
    insn = {5'(f5), wd, ~msk, 10'h0, 3'(wc), 5'h0, 7'(op7)};
    sew_code = 2'(sewc);
    vstart_in = IDXW'(vs);
    vl = IDXW'(vlen);
    mask_in = mv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 0; got_ill = 0;
    for (int t = 0; t < 3000; t++) begin
      if (done) begin got_done = 1; break; end
      if (illegal) begin got_ill = 1; break; end
      if (poke && t == 2) begin
        insn = {5'b00001, 1'b1, 1'b1, 10'h0, 3'b111, 5'h0, 7'h2F};
        vstart_in = '0;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    if (exp_ill) begin
      check(got_ill && !got_done, {tag, " illegal pulse"}, {62'h0, got_ill, got_done}, 64'h2);
      check(n_req == req0, {tag, " no access"}, 64'(n_req - req0), 64'h0);
      check(64'(vstart_q) == vprev, {tag, " vstart kept"}, 64'(vstart_q), vprev);
    end else begin
      check(got_done && !got_ill, {tag, " R11 done"}, {62'h0, got_ill, got_done}, 64'h1);
      check(n_req - req0 == exp_req, {tag, " R9 R10 access count"}, 64'(n_req - req0), 64'(exp_req));
      mem_ok = 1; a = 0;
      for (int w = 0; w < 64; w++) if (mem[w] !== exp_mem[w] && mem_ok) begin mem_ok = 0; a = w; end
      check(mem_ok, {tag, " R2 R4 R5 R6 memory"}, mem[a], exp_mem[a]);
      opd_ok = 1; a = 0;
      for (int i = 0; i < NELEM; i++) if (opd_rf[i] !== exp_opd[i] && opd_ok) begin opd_ok = 0; a = i; end
      check(opd_ok, {tag, " R7 destination"}, opd_rf[a], exp_opd[a]);
      check(vstart_q == '0, {tag, " R8 vstart cleared"}, 64'(vstart_q), 64'h0);
    end
  endtask

  initial begin
    int fcodes [9] = '{1, 0, 4, 12, 8, 16, 20, 24, 28};
    int wcodes [4] = '{0, 5, 6, 7};
    logic [63:0] r;
    repeat (3) @(negedge clk);
    check(!busy && !done && !illegal && !mem_req_valid && !mem_lock && vstart_q == '0,
          "R12 reset state", {59'h0, busy, done, illegal, mem_req_valid, mem_lock}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // main sweep: every function, width, index width, write-back and mask mode
    for (int f = 0; f < 9; f++)
      for (int s = 2; s < 4; s++)
        for (int w = 0; w < 4; w++)
          for (int wd = 0; wd < 2; wd++)
            for (int m = 0; m < 2; m++) begin
              rnd(r);
              run(fcodes[f], wd[0], m[0], wcodes[w], s, 'h2F, int'(r % 3),
                  3 + int'((r >> 8) % 6), 1'b0, 1'b0, (fcodes[f] >= 16) ? "R6 R1" : "R5 R1");
            end
    // R13: start pulse while busy is ignored
    run(0, 1'b1, 1'b0, 7, 3, 'h2F, 0, 8, 1'b1, 1'b0, "R13 busy start");
    run(20, 1'b0, 1'b0, 6, 2, 'h2F, 1, 6, 1'b1, 1'b0, "R13 busy start");
    // R11: empty element range
    run(0, 1'b1, 1'b0, 7, 3, 'h2F, 5, 5, 1'b0, 1'b0, "R11 empty range");
    run(0, 1'b1, 1'b0, 7, 3, 'h2F, 7, 2, 1'b0, 1'b0, "R11 empty range");
    // make vstart_q non-zero is not possible after done; illegal leaves it at zero
    run(0, 1'b1, 1'b0, 7, 0, 'h2F, 1, 4, 1'b0, 1'b1, "R3 sew 8");
    run(0, 1'b1, 1'b0, 7, 1, 'h2F, 1, 4, 1'b0, 1'b1, "R3 sew 16");
    run(0, 1'b1, 1'b0, 7, 3, 'h27, 1, 4, 1'b0, 1'b1, "R1 bad opcode");
    run(2, 1'b1, 1'b0, 7, 3, 'h2F, 1, 4, 1'b0, 1'b1, "R1 bad function");
    run(0, 1'b1, 1'b0, 1, 2, 'h2F, 1, 4, 1'b0, 1'b1, "R2 bad index width");
    check(bad_addr == 0, "R4 address range", 64'(bad_addr), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule